// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block decides, in the same cycle, whether a memory access is permitted. It keeps a small table of protection regions. Each region is a power-of-two window placed on a base that is a multiple of its own size, so matching costs one mask and one compare. Every region is cut into sixteen equal slices. One bit per slice picks which of the region's two permission codes governs that slice. Each code grants read, write and execute rights separately for privileged and unprivileged callers.

Software loads an entry through a single-cycle write port. A write with a bad size code or a base that is not aligned to the region size is refused, and the stored entry stays as it was. Each access presents an address, a kind and a privilege level. The guard answers allow or deny combinationally. A denied request is reported as a data-side fault or an instruction-side fault. A global enable input turns checking off.

Top module: `mem_guard`

## Requirements
- R1: A size code N in 11..30 makes a region of 2<<N bytes (11 = 4 KB, 30 = 2 GB). An address falls in a valid region when the address, with its low N+1 bits cleared, equals the stored base.
- R2: A write whose base has any bit set among the low N+1 bits is refused. `cfg_reject` is high in that same cycle, and the addressed entry keeps its previous contents.
- R3: A write with a size code below 11 or above 30 is refused in the same way as R2.
- R4: An entry whose valid bit is 0 never matches any address.
- R5: The slice index of an address within a region of code N is address bits [N:N-3]. A select bit of 0 applies permission code A to that slice, and a select bit of 1 applies code B.
- R6: The 4-bit permission code gives rights as privileged/unprivileged: 0 none/none, 1 R/none, 2 RX/none, 3 RW/none, 4 RWX/none, 5 R/R, 6 RX/RX, 7 RW/R, 8 RW/RW, 9 RWX/RWX. Codes 10 to 15 grant nothing.
- R7: The access kind encodes 00 read, 01 write and 10 execute. Kind 11 is never permitted while checking is on.
- R8: When several valid regions match, the lowest-indexed one alone decides the outcome.
- R9: While `prot_en` is 1, an access that matches no valid region is denied.
- R10: While `prot_en` is 0, `acc_allow` is 1 and no fault output is raised.
- R11: A denied access with `acc_req` high raises `fault_insn` for kind 10 and `fault_data` for any other kind. The two faults are never high together, and neither is high when `acc_req` is 0 or the access is allowed.
- R12: The decision depends only on the current access inputs and the stored table. An accepted write changes the table at the clock edge that samples it. An access in the same cycle as a write is judged against the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prot_en | input | 1 | Global checking enable |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | 5 | Region size code |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_sel | input | 16 | Per-slice choice between codes A (0) and B (1) |
| cfg_perm_a | input | 4 | Permission code A |
| cfg_perm_b | input | 4 | Permission code B |
| cfg_reject | output | 1 | Current write is refused |
| acc_req | input | 1 | Access is being presented |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | Access kind |
| acc_priv | input | 1 | 1 = privileged caller |
| acc_allow | output | 1 | Access is permitted |
| fault_data | output | 1 | Denied data access |
| fault_insn | output | 1 | Denied instruction fetch |

## Verification
A table write and an access can fall in the same cycle, and both can target the same entry. The bench provokes this by writing a fresh entry while presenting an address inside the new window. It expects a deny with a data fault just before the clock edge, and a grant right after it. The bench also overlaps two regions with conflicting rights and probes addresses at slice edges and at the outer limits of a 4 KB and a 2 GB region. Refused writes are judged by probing the old entry afterwards.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;

  localparam int unsigned SIZE_W   = 5;
  localparam int unsigned PERM_W   = 4;
  localparam int unsigned SUB_BITS = 4;
  localparam int unsigned SUB_CNT  = 1 << SUB_BITS;
  localparam int unsigned SIZE_MIN = 11;
  localparam int unsigned SIZE_MAX = 30;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  // Mask of the byte offsets inside a region of code s (2 << s bytes).
  function automatic logic [63:0] region_mask(input logic [SIZE_W-1:0] s);
    return (64'd1 << ({1'b0, s} + 6'd1)) - 64'd1;
  endfunction

  function automatic logic size_ok(input logic [SIZE_W-1:0] s);
    return (s >= SIZE_W'(SIZE_MIN)) && (s <= SIZE_W'(SIZE_MAX));
  endfunction

  function automatic rights_t perm_decode(input logic [PERM_W-1:0] code,
                                          input logic priv);
    rights_t p;
    rights_t u;
    p = '0;
    u = '0;
    case (code)
      4'd1:    p = 3'b100;
      4'd2:    p = 3'b101;
      4'd3:    p = 3'b110;
      4'd4:    p = 3'b111;
      4'd5:    begin p = 3'b100; u = 3'b100; end
      4'd6:    begin p = 3'b101; u = 3'b101; end
      4'd7:    begin p = 3'b110; u = 3'b100; end
      4'd8:    begin p = 3'b110; u = 3'b110; end
      4'd9:    begin p = 3'b111; u = 3'b111; end
      default: begin p = 3'b000; u = 3'b000; end
    endcase
    return priv ? p : u;
  endfunction

  function automatic logic kind_ok(input rights_t r, input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_RD:  ok = r.rd;
      ACC_WR:  ok = r.wr;
      ACC_EX:  ok = r.ex;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mg_region_table.sv
module mg_region_table
  import mem_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [IDX_W-1:0]                     cfg_idx,
  input  logic [ADDR_W-1:0]                    cfg_base,
  input  logic [SIZE_W-1:0]                    cfg_size,
  input  logic                                 cfg_valid,
  input  logic [SUB_CNT-1:0]                   cfg_sel,
  input  logic [PERM_W-1:0]                    cfg_perm_a,
  input  logic [PERM_W-1:0]                    cfg_perm_b,
  output logic                                 cfg_reject,
  output logic [NUM_REG-1:0][ADDR_W-1:0]       base_q,
  output logic [NUM_REG-1:0][SIZE_W-1:0]       size_q,
  output logic [NUM_REG-1:0]                   valid_q,
  output logic [NUM_REG-1:0][SUB_CNT-1:0]      sel_q,
  output logic [NUM_REG-1:0][PERM_W-1:0]       pa_q,
  output logic [NUM_REG-1:0][PERM_W-1:0]       pb_q
);

  logic [NUM_REG-1:0][ADDR_W-1:0]  base_d;
  logic [NUM_REG-1:0][SIZE_W-1:0]  size_d;
  logic [NUM_REG-1:0]              valid_d;
  logic [NUM_REG-1:0][SUB_CNT-1:0] sel_d;
  logic [NUM_REG-1:0][PERM_W-1:0]  pa_d;
  logic [NUM_REG-1:0][PERM_W-1:0]  pb_d;
  logic [NUM_REG-1:0]              wr_sel;
  logic [ADDR_W-1:0]               wr_mask;
  logic                            size_bad;
  logic                            base_bad;
  logic                            idx_bad;

  assign wr_mask  = ADDR_W'(region_mask(cfg_size));
  assign size_bad = !size_ok(cfg_size);
  assign base_bad = |(cfg_base & wr_mask);

  generate
    if ((1 << IDX_W) > NUM_REG) begin : g_idx_chk
      assign idx_bad = ({1'b0, cfg_idx} >= (IDX_W+1)'(NUM_REG));
    end else begin : g_idx_full
      assign idx_bad = 1'b0;
    end
  endgenerate

  assign cfg_reject = cfg_we && (size_bad || base_bad || idx_bad);

  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : g_wsel
      assign wr_sel[g] = cfg_we && !cfg_reject && (cfg_idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    base_d  = base_q;
    size_d  = size_q;
    valid_d = valid_q;
    sel_d   = sel_q;
    pa_d    = pa_q;
    pb_d    = pb_q;
    for (int i = 0; i < NUM_REG; i++) begin
      if (wr_sel[i]) begin
        base_d[i]  = cfg_base;
        size_d[i]  = cfg_size;
        valid_d[i] = cfg_valid;
        sel_d[i]   = cfg_sel;
        pa_d[i]    = cfg_perm_a;
        pb_d[i]    = cfg_perm_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      size_q  <= '0;
      valid_q <= '0;
      sel_q   <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
    end else if (|wr_sel) begin
      base_q  <= base_d;
      size_q  <= size_d;
      valid_q <= valid_d;
      sel_q   <= sel_d;
      pa_q    <= pa_d;
      pb_q    <= pb_d;
    end
  end

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |=> ($stable(base_q) && $stable(size_q) && $stable(valid_q) &&
                    $stable(sel_q) && $stable(pa_q) && $stable(pb_q)));

  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : g_chk
      // R1
      aligned_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[g] |-> ((base_q[g] & ADDR_W'(region_mask(size_q[g]))) == '0));
      // R3
      size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[g] |-> size_ok(size_q[g]));
    end
  endgenerate

endmodule

// File: rtl/mg_region_match.sv
module mg_region_match
  import mem_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_REG = 8
) (
  input  logic [ADDR_W-1:0]                    acc_addr,
  input  logic [1:0]                           acc_kind,
  input  logic                                 acc_priv,
  input  logic [NUM_REG-1:0][ADDR_W-1:0]       base_q,
  input  logic [NUM_REG-1:0][SIZE_W-1:0]       size_q,
  input  logic [NUM_REG-1:0]                   valid_q,
  input  logic [NUM_REG-1:0][SUB_CNT-1:0]      sel_q,
  input  logic [NUM_REG-1:0][PERM_W-1:0]       pa_q,
  input  logic [NUM_REG-1:0][PERM_W-1:0]       pb_q,
  output logic [NUM_REG-1:0]                   hit,
  output logic [NUM_REG-1:0]                   ok
);

  localparam logic [SIZE_W-1:0] SUB_SHIFT = SIZE_W'(SUB_BITS - 1);

  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
      logic [ADDR_W-1:0]   mask;
      logic [SUB_BITS-1:0] sub;
      logic [PERM_W-1:0]   code;
      rights_t             rights;

      assign mask   = ADDR_W'(region_mask(size_q[g]));
      assign hit[g] = valid_q[g] && ((acc_addr & ~mask) == base_q[g]);
      // slice index: the four address bits just below the region size
      assign sub    = SUB_BITS'(acc_addr >> (size_q[g] - SUB_SHIFT));
      assign code   = sel_q[g][sub] ? pb_q[g] : pa_q[g];
      assign rights = perm_decode(code, acc_priv);
      assign ok[g]  = kind_ok(rights, acc_kind);
    end
  endgenerate

endmodule

// File: rtl/mg_pick.sv
module mg_pick #(
  parameter int unsigned NUM_REG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REG-1:0] hit,
  input  logic [NUM_REG-1:0] ok,
  output logic               any_hit,
  output logic               win_ok
);

  logic [NUM_REG-1:0] win_oh;

  always_comb begin
    win_oh = '0;
    for (int i = NUM_REG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
      end
    end
  end

  assign any_hit = |hit;
  assign win_ok  = |(win_oh & ok);

  // R8
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((win_oh != '0) == (hit != '0)));

  // R8
  winner_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & ~hit) == '0);

endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [4:0]        cfg_size,
  input  logic              cfg_valid,
  input  logic [15:0]       cfg_sel,
  input  logic [3:0]        cfg_perm_a,
  input  logic [3:0]        cfg_perm_b,
  output logic              cfg_reject,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              acc_allow,
  output logic              fault_data,
  output logic              fault_insn
);

  logic [1:0]                      rst_pipe;
  logic                            rst_sync_n;
  logic [NUM_REG-1:0][ADDR_W-1:0]  base_q;
  logic [NUM_REG-1:0][SIZE_W-1:0]  size_q;
  logic [NUM_REG-1:0]              valid_q;
  logic [NUM_REG-1:0][SUB_CNT-1:0] sel_q;
  logic [NUM_REG-1:0][PERM_W-1:0]  pa_q;
  logic [NUM_REG-1:0][PERM_W-1:0]  pb_q;
  logic [NUM_REG-1:0]              hit;
  logic [NUM_REG-1:0]              ok;
  logic                            any_hit;
  logic                            win_ok;
  logic                            denied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mg_region_table #(
    .ADDR_W (ADDR_W),
    .NUM_REG(NUM_REG),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_base  (cfg_base),
    .cfg_size  (cfg_size),
    .cfg_valid (cfg_valid),
    .cfg_sel   (cfg_sel),
    .cfg_perm_a(cfg_perm_a),
    .cfg_perm_b(cfg_perm_b),
    .cfg_reject(cfg_reject),
    .base_q    (base_q),
    .size_q    (size_q),
    .valid_q   (valid_q),
    .sel_q     (sel_q),
    .pa_q      (pa_q),
    .pb_q      (pb_q)
  );

  mg_region_match #(
    .ADDR_W (ADDR_W),
    .NUM_REG(NUM_REG)
  ) u_match (
    .acc_addr(acc_addr),
    .acc_kind(acc_kind),
    .acc_priv(acc_priv),
    .base_q  (base_q),
    .size_q  (size_q),
    .valid_q (valid_q),
    .sel_q   (sel_q),
    .pa_q    (pa_q),
    .pb_q    (pb_q),
    .hit     (hit),
    .ok      (ok)
  );

  mg_pick #(
    .NUM_REG(NUM_REG)
  ) u_pick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hit    (hit),
    .ok     (ok),
    .any_hit(any_hit),
    .win_ok (win_ok)
  );

  assign acc_allow  = !prot_en || (any_hit && win_ok);
  assign denied     = acc_req && !acc_allow;
  assign fault_insn = denied && (acc_kind == ACC_EX);
  assign fault_data = denied && (acc_kind != ACC_EX);

  // R10
  open_when_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !prot_en |-> (acc_allow && !fault_data && !fault_insn));

  // R9
  no_match_deny_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prot_en && !any_hit) |-> !acc_allow);

  // R7
  reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prot_en && acc_kind == ACC_RSV) |-> !acc_allow);

  // R11
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fault_data && fault_insn) && !((fault_data || fault_insn) && acc_allow));

  // R11
  fault_side_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_insn |-> (acc_kind == ACC_EX && acc_req));

endmodule

// File: tb/mem_guard_test.sv
`timescale 1ns/100ps
module mem_guard_test;

  logic        clk;
  logic        rst_n;
  logic        prot_en;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [4:0]  cfg_size;
  logic        cfg_valid;
  logic [15:0] cfg_sel;
  logic [3:0]  cfg_perm_a;
  logic [3:0]  cfg_perm_b;
  logic        cfg_reject;
  logic        acc_req;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        acc_priv;
  logic        acc_allow;
  logic        fault_data;
  logic        fault_insn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  mem_guard uut (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .cfg_perm_a(cfg_perm_a), .cfg_perm_b(cfg_perm_b), .cfg_reject(cfg_reject),
    .acc_req(acc_req), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .acc_allow(acc_allow), .fault_data(fault_data),
    .fault_insn(fault_insn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: addr[37:6] kind[5:4] priv[3] expected {allow,fault_data,fault_insn}[2:0]
  localparam int NV = 24;
  localparam logic [37:0] VEC [NV] = '{
    {32'h0000_1000, 2'd0, 1'b0, 3'b010},  // R5 R6 slice 0 uses B, unpriv none
    {32'h0000_1000, 2'd0, 1'b1, 3'b100},  // R6 B priv read
    {32'h0000_10FF, 2'd1, 1'b1, 3'b010},  // R5 last byte of slice 0
    {32'h0000_1100, 2'd1, 1'b0, 3'b100},  // R5 first byte of slice 1, A
    {32'h0000_1EFF, 2'd1, 1'b0, 3'b100},  // R5 slice 14
    {32'h0000_1F00, 2'd1, 1'b0, 3'b010},  // R8 slice 15 B beats region 2
    {32'h0000_1F00, 2'd0, 1'b1, 3'b100},  // R6
    {32'h0000_1100, 2'd2, 1'b1, 3'b001},  // R11 fetch denied
    {32'h0000_2000, 2'd1, 1'b0, 3'b100},  // R1 region 2 only
    {32'h0000_0FFF, 2'd2, 1'b0, 3'b100},  // R1
    {32'h0000_3FFF, 2'd1, 1'b0, 3'b100},  // R1 last byte of 16 KB
    {32'h0000_4000, 2'd0, 1'b1, 3'b010},  // R9 just past region 2
    {32'h8000_0000, 2'd2, 1'b0, 3'b100},  // R1 2 GB base
    {32'h8000_0000, 2'd1, 1'b1, 3'b010},  // R6 RX code refuses write
    {32'h9FFF_FFFF, 2'd1, 1'b1, 3'b010},  // R5 slice 3 uses A
    {32'hA000_0000, 2'd1, 1'b1, 3'b100},  // R5 slice 4 uses B
    {32'hA000_0000, 2'd0, 1'b0, 3'b010},  // R6 B unpriv none
    {32'hBFFF_FFFC, 2'd2, 1'b0, 3'b001},  // R11 slice 7 fetch fault
    {32'hC000_0000, 2'd2, 1'b0, 3'b100},  // R5 slice 8 back to A
    {32'hFFFF_FFFF, 2'd0, 1'b0, 3'b100},  // R1 top address
    {32'h7FFF_FFFF, 2'd0, 1'b1, 3'b010},  // R9 below 2 GB region
    {32'h0001_0800, 2'd0, 1'b1, 3'b010},  // R2 refused entry absent
    {32'h0004_0000, 2'd0, 1'b1, 3'b010},  // R4 invalid entry
    {32'h0000_1100, 2'd3, 1'b1, 3'b010}   // R7 reserved kind
  };

  task automatic check(input string req, input string what,
                       input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] base,
                           input logic [4:0] size, input logic valid,
                           input logic [15:0] sel, input logic [3:0] pa,
                           input logic [3:0] pb, output logic rej);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_size = size;
    cfg_valid = valid; cfg_sel = sel; cfg_perm_a = pa; cfg_perm_b = pb;
    #1 rej = cfg_reject;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [31:0] addr, input logic [1:0] kind,
                       input logic priv, output logic [2:0] res);
    @(negedge clk);
    acc_addr = addr; acc_kind = kind; acc_priv = priv;
    #1 res = {acc_allow, fault_data, fault_insn};
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       rej;
    logic [2:0] res;
    rst_n = 1'b0; prot_en = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0;
    cfg_size = '0; cfg_valid = 1'b0; cfg_sel = '0; cfg_perm_a = '0;
    cfg_perm_b = '0; acc_req = 1'b1; acc_addr = '0; acc_kind = 2'd0;
    acc_priv = 1'b1;

    // reset state: empty table denies (R9)
    probe(32'h0, 2'd0, 1'b1, res);
    check("R9", "deny in reset", res, 3'b010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    probe(32'h0, 2'd0, 1'b1, res);
    check("R9", "deny after reset", res, 3'b010);
    check("R2", "no reject when idle", {2'b00, cfg_reject}, 3'b000);

    // table setup
    cfg_write(3'd0, 32'h0000_1000, 5'd11, 1'b1, 16'h8001, 4'd8, 4'd1, rej);
    check("R1", "4 KB write accepted", {2'b00, rej}, 3'b000);
    cfg_write(3'd1, 32'h8000_0000, 5'd30, 1'b1, 16'h00F0, 4'd6, 4'd4, rej);
    check("R1", "2 GB write accepted", {2'b00, rej}, 3'b000);
    cfg_write(3'd2, 32'h0000_0000, 5'd13, 1'b1, 16'h0000, 4'd9, 4'd0, rej);
    check("R8", "overlap write accepted", {2'b00, rej}, 3'b000);
    cfg_write(3'd3, 32'h0001_0800, 5'd12, 1'b1, 16'h0000, 4'd9, 4'd9, rej);
    check("R2", "misaligned base refused", {2'b00, rej}, 3'b001);
    cfg_write(3'd4, 32'h0004_0000, 5'd11, 1'b0, 16'h0000, 4'd9, 4'd9, rej);
    check("R4", "invalid entry write accepted", {2'b00, rej}, 3'b000);

    // vector walk: R1 R5 R6 R7 R8 R9 R11
    for (int k = 0; k < NV; k++) begin
      probe(VEC[k][37:6], VEC[k][5:4], VEC[k][3], res);
      check("R1/R5/R6/R7/R8/R9/R11", $sformatf("vector %0d", k), res, VEC[k][2:0]);
    end

    // R2: refused write over a live entry leaves it intact
    cfg_write(3'd0, 32'h0000_1800, 5'd11, 1'b1, 16'hFFFF, 4'd0, 4'd0, rej);
    check("R2", "live entry misaligned refused", {2'b00, rej}, 3'b001);
    probe(32'h0000_1100, 2'd1, 1'b0, res);
    check("R2", "old entry still governs", res, 3'b100);

    // R3: size codes outside range
    cfg_write(3'd5, 32'h0005_0000, 5'd10, 1'b1, 16'h0000, 4'd9, 4'd9, rej);
    check("R3", "size code 10 refused", {2'b00, rej}, 3'b001);
    cfg_write(3'd5, 32'h0000_0000, 5'd31, 1'b1, 16'h0000, 4'd9, 4'd9, rej);
    check("R3", "size code 31 refused", {2'b00, rej}, 3'b001);
    probe(32'h0005_0000, 2'd0, 1'b1, res);
    check("R3", "refused entry absent", res, 3'b010);

    // R12: write and access in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_base = 32'h0004_0000; cfg_size = 5'd11;
    cfg_valid = 1'b1; cfg_sel = 16'h0000; cfg_perm_a = 4'd9; cfg_perm_b = 4'd9;
    acc_addr = 32'h0004_0000; acc_kind = 2'd0; acc_priv = 1'b0;
    #1 check("R12", "same cycle sees old entry",
             {acc_allow, fault_data, fault_insn}, 3'b010);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 check("R12", "next cycle sees new entry",
             {acc_allow, fault_data, fault_insn}, 3'b100);

    // R4: clearing the valid bit removes the region
    cfg_write(3'd4, 32'h0004_0000, 5'd11, 1'b0, 16'h0000, 4'd9, 4'd9, rej);
    probe(32'h0004_0000, 2'd0, 1'b0, res);
    check("R4", "cleared entry no match", res, 3'b010);

    // R11: no fault without a request
    acc_req = 1'b0;
    probe(32'h0004_0000, 2'd2, 1'b0, res);
    check("R11", "no fault without request", res, 3'b000);
    acc_req = 1'b1;

    // R10: checking disabled
    prot_en = 1'b0;
    probe(32'h7FFF_FFFF, 2'd1, 1'b0, res);
    check("R10", "unmatched allowed when off", res, 3'b100);
    probe(32'h0000_1100, 2'd3, 1'b0, res);
    check("R10", "reserved kind allowed when off", res, 3'b100);
    prot_en = 1'b1;
    probe(32'h7FFF_FFFF, 2'd1, 1'b0, res);
    check("R9", "unmatched denied when on", res, 3'b010);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule